// File: doc/BRIEF.md
# Serial Flash Clock Divider with Gates

This block derives the timing for a serial-flash controller from one fast source clock. It does not create new clock nets. Instead it produces single-cycle clock-enable strobes that downstream logic uses with the source clock. Three rates are produced:

- A prescaled rate: the source clock divided by 5 or 6.
- A main flash rate: the prescaled rate divided again by 2, 4, 6 or 8.
- A half rate: the main rate divided by two.

The block also provides a level waveform at the prescaled rate. For odd ratios, this level is high for floor(N/2) source cycles of each period.

One control register holds every setting. It contains the two ratio fields and two gate bits. Each gate bit stops its clock when it is set. The register is written with a write strobe and can always be read back.

The half rate is built from the gated main strobes. Stopping the main clock therefore also stops the half-rate clock. A two-state phase machine builds the half rate:

- `PH_EVEN`: the next main strobe moves it to `PH_ODD` and produces no half strobe.
- `PH_ODD`: the next main strobe moves it back to `PH_EVEN` and produces a half strobe, unless the half gate is set.

Top module: `sfclk_gen`

## Requirements
- R1: After reset the control register reads 0x0311, which means both gates are set, source code 2 and main code 1. While that value holds, `main_ce` and `half_ce` stay low.
- R2: The register layout is as follows: bits [2:0] are the main divider code, bits [4:3] are the source divider code, bit 8 is the main gate and bit 9 is the half gate. All other bits read 0, and the read value changes only after a write.
- R3: Source code 3 makes `src_ce` a one-cycle pulse every 6 source cycles. Source code 2 makes it a pulse every 5 cycles.
- R4: Source codes 0 and 1 behave like code 2, which is divide by 5.
- R5: Main codes 1, 3, 5 and 7 give one `main_ce` pulse every 2, 4, 6 or 8 `src_ce` pulses. Each `main_ce` pulse coincides with a `src_ce` pulse.
- R6: An even main code behaves like the next higher odd code. For example, 0 acts as 1 and 6 acts as 7.
- R7: While the main gate bit is 1, `main_ce` never pulses.
- R8: `half_ce` pulses on every second `main_ce` pulse and only together with one. The half gate bit set to 1 suppresses it.
- R9: While the main gate is set, `half_ce` never pulses, whatever the half gate is.
- R10: Within each source period of N cycles, `src_lvl` is high for floor(N/2) cycles.
- R11: The source and main counters stay within the range of the current ratio, including right after a ratio is reduced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| src_ce | output | 1 | Prescaled-rate enable strobe |
| src_lvl | output | 1 | Prescaled-rate level waveform |
| main_ce | output | 1 | Main flash clock enable strobe |
| half_ce | output | 1 | Half-rate clock enable strobe |

## Verification
Some properties are checked by assertions on every cycle:

- Strobe nesting: a half strobe only with a main strobe, and a main strobe only with a prescaled strobe.
- The counters stay inside the current ratio (R11).
- The read value is stable when no write occurs.

The bench's measured scenarios cover what assertions cannot show:

- The actual pulse spacings for every code, including the folded codes.
- The duty of the level output.
- The suppression by each gate.
- The reset value and the masking of unused bits on readback.

// File: rtl/sfclk_pkg.sv
package sfclk_pkg;
    localparam int REG_W         = 16;
    localparam int MAIN_LSB      = 0;
    localparam int MAIN_W        = 3;
    localparam int SRC_LSB       = 3;
    localparam int SRC_W         = 2;
    localparam int GATE_MAIN_BIT = 8;
    localparam int GATE_HALF_BIT = 9;
    localparam logic [REG_W-1:0] RST_VAL = 16'h0311;

    typedef struct packed {
        logic              gate_half;
        logic              gate_main;
        logic [SRC_W-1:0]  src_code;
        logic [MAIN_W-1:0] main_code;
    } cfg_t;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } half_ph_t;
endpackage

// File: rtl/sfclk_cfg_reg.sv
module sfclk_cfg_reg
    import sfclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output cfg_t             cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.gate_half <= RST_VAL[GATE_HALF_BIT];
            cfg_q.gate_main <= RST_VAL[GATE_MAIN_BIT];
            cfg_q.src_code  <= RST_VAL[SRC_LSB +: SRC_W];
            cfg_q.main_code <= RST_VAL[MAIN_LSB +: MAIN_W];
        end else if (we) begin
            cfg_q.gate_half <= wdata[GATE_HALF_BIT];
            cfg_q.gate_main <= wdata[GATE_MAIN_BIT];
            cfg_q.src_code  <= wdata[SRC_LSB +: SRC_W];
            cfg_q.main_code <= wdata[MAIN_LSB +: MAIN_W];
        end
    end

    always_comb begin
        rdata                         = '0;
        rdata[GATE_HALF_BIT]          = cfg_q.gate_half;
        rdata[GATE_MAIN_BIT]          = cfg_q.gate_main;
        rdata[SRC_LSB +: SRC_W]       = cfg_q.src_code;
        rdata[MAIN_LSB +: MAIN_W]     = cfg_q.main_code;
    end

    assign cfg = cfg_q;

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/sfclk_div.sv
module sfclk_div #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] cnt,
    output logic          tick
);
    logic wrap;

    assign wrap = (cnt >= last);
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (en)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (cnt <= $past(last)));
endmodule

// File: rtl/sfclk_half_fsm.sv
module sfclk_half_fsm
    import sfclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_ce,
    input  logic gate_half,
    output logic half_ce
);
    half_ph_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PH_EVEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        half_ce = 1'b0;
        unique case (state_q)
            PH_EVEN: begin
                if (main_ce)
                    state_d = PH_ODD;
            end
            PH_ODD: begin
                if (main_ce) begin
                    state_d = PH_EVEN;
                    half_ce = !gate_half;
                end
            end
            default: state_d = PH_EVEN;
        endcase
    end

    // R8
    half_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_ce |=> (state_q == PH_EVEN));
endmodule

// File: rtl/sfclk_gen.sv
module sfclk_gen
    import sfclk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             src_ce,
    output logic             src_lvl,
    output logic             main_ce,
    output logic             half_ce
);
    localparam logic [CNT_W-1:0] SRC_LAST_5 = CNT_W'(4);
    localparam logic [CNT_W-1:0] SRC_LAST_6 = CNT_W'(5);

    cfg_t             cfg;
    logic [CNT_W-1:0] src_last, main_last;
    logic [CNT_W-1:0] src_cnt, main_cnt;
    logic [CNT_W-1:0] src_hi;
    logic             main_tick;

    sfclk_cfg_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    // Source ratio: code 3 gives 6, every other code gives 5.
    assign src_last = (cfg.src_code == 2'd3) ? SRC_LAST_6 : SRC_LAST_5;
    // Main ratio: odd code c gives c+1, even codes fold up to the next odd one.
    assign main_last = CNT_W'(cfg.main_code | 3'b001);
    assign src_hi    = (src_last + 1'b1) >> 1;

    sfclk_div #(.CW(CNT_W)) u_src_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .last  (src_last),
        .cnt   (src_cnt),
        .tick  (src_ce)
    );

    assign src_lvl = (src_cnt < src_hi);

    sfclk_div #(.CW(CNT_W)) u_main_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (src_ce),
        .last  (main_last),
        .cnt   (main_cnt),
        .tick  (main_tick)
    );

    assign main_ce = main_tick && !cfg.gate_main;

    sfclk_half_fsm u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_ce   (main_ce),
        .gate_half (cfg.gate_half),
        .half_ce   (half_ce)
    );

    // R5
    main_in_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_ce |-> src_ce);
    // R9
    half_in_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_ce |-> main_ce);
    // R7
    main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[GATE_MAIN_BIT] |-> !main_ce);
    // R10
    src_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ce |-> !src_lvl);
endmodule

// File: tb/sfclk_gen_tb_top.sv
module sfclk_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        src_ce, src_lvl, main_ce, half_ce;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sfclk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_ce    (src_ce),
        .src_lvl   (src_lvl),
        .main_ce   (main_ce),
        .half_ce   (half_ce)
    );

    function automatic int exp_src(input logic [15:0] v);
        return (v[4:3] == 2'd3) ? 6 : 5;
    endfunction

    function automatic int exp_main(input logic [15:0] v);
        return int'(v[2:0] | 3'b001) + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
        // R2 readback of the written value with unused bits cleared
        chk(reg_rdata == (v & 16'h031F), "R2", int'(reg_rdata), int'(v & 16'h031F));
    endtask

    // Measures pulse spacing and level duty for the current register value.
    task automatic measure(input logic [15:0] v);
        int ns = exp_src(v);
        int nm = exp_main(v);
        bit gm = v[8];
        bit gh = v[9];
        int ls = -1, lm = -1, lh = -1;
        int cs = 0, cm = 0, chh = 0, hi = 0;
        repeat (120) @(negedge clk);
        for (int t = 0; t < 420; t++) begin
            @(negedge clk);
            hi += int'(src_lvl);
            if (src_ce) begin
                if (ls >= 0) begin
                    chk((t - ls) == ns, "R3/R4 src spacing", t - ls, ns);
                    chk(hi == ns / 2, "R10 src_lvl duty", hi, ns / 2);
                end
                ls = t; hi = 0; cs++;
            end
            if (main_ce) begin
                chk(src_ce, "R5 main with src", 0, 1);
                if (lm >= 0)
                    chk((t - lm) == ns * nm, "R5/R6 main spacing", t - lm, ns * nm);
                lm = t; cm++;
            end
            if (half_ce) begin
                chk(main_ce, "R8 half with main", 0, 1);
                if (lh >= 0)
                    chk((t - lh) == 2 * ns * nm, "R8 half spacing", t - lh, 2 * ns * nm);
                lh = t; chh++;
            end
        end
        chk(cs > 0, "R3 src pulses present", cs, 1);
        if (gm) chk(cm == 0, "R7 main gated", cm, 0);
        else    chk(cm > 0, "R5 main pulses present", cm, 1);
        if (gm)      chk(chh == 0, "R9 half stopped by main gate", chh, 0);
        else if (gh) chk(chh == 0, "R8 half gated", chh, 0);
        else         chk(chh > 0, "R8 half pulses present", chh, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        chk(reg_rdata == 16'h0311, "R1 reset value", int'(reg_rdata), 16'h0311);
        measure(16'h0311);
        // R2 unused bits read zero
        wr(16'hFFFF);
        measure(16'hFFFF);
        // R4 source codes 0 and 1, R6 even main codes
        wr(16'h0000);
        measure(16'h0000);
        wr(16'h000A);
        measure(16'h000A);
        wr(16'h0018);
        measure(16'h0018);
        wr(16'h001E);
        measure(16'h001E);
        // R8 only half gated; R9 main gated, half open
        wr(16'h0213);
        measure(16'h0213);
        wr(16'h0105);
        measure(16'h0105);
        // R11 shrink ratio from the largest setting
        wr(16'h001F);
        repeat (37) @(negedge clk);
        wr(16'h0000);
        measure(16'h0000);
        void'($urandom(32'd4242));
        for (int i = 0; i < 10; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            wr(v);
            measure(v);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule